// File: doc/BRIEF.md
# Mixed-Signal Boundary-Scan Instruction and Data-Path Logic

This block holds the instruction register and the data-register path of a small mixed-signal boundary-scan component. An external test-access state machine supplies one-cycle strobes for each controller state: reset, capture, shift and update, for both the instruction side and the data side. The block turns those strobes into the serial path between TDI and TDO. It also produces the mode signals that steer the digital and analog pin cells.

Four instructions are recognised. The first is external test, where the digital cells drive their pins from the update stage and the analog cells obey their control words. The second is probe, where the digital cells stay transparent but the analog cells and the test-bus links are active. The third is sample/preload, where every cell stays in mission mode. The fourth is bypass. Any other opcode behaves as bypass.

The boundary register is 14 bits long. Its field order is fixed, because the neighbouring cells decode their fields by position. A one-bit bypass register stands in for it whenever the decoded instruction does not select it.

Top module: `mxbs_ctl`

## Requirements
- R1: After synchronous reset, every mode output and every update-stage output is 0, tdo_en is 0, and the active instruction is bypass.
- R2: Capture of the instruction register loads 8'h01. During the instruction shift, TDO therefore emits 1 first and then seven 0s.
- R3: Instruction bits are shifted in least significant bit first. The opcode takes effect on the rising edge that ends the update-instruction cycle. Opcode 8'h00 gives dig_test=1 and ana_test=1. Opcode 8'h01 gives dig_test=0 and ana_test=1. Opcodes 8'h02 and 8'hFF give dig_test=0 and ana_test=0.
- R4: Any opcode other than 8'h00, 8'h01 and 8'h02 acts exactly like 8'hFF: both modes are 0 and the one-bit bypass path is used.
- R5: With bypass active, the data path is one bit long. Capture loads 0, and each shifted bit reappears at TDO one shift later.
- R6: With opcodes 8'h00, 8'h01 and 8'h02, the 14-bit boundary register is selected. Capture loads {bif_obs[3:0], ain_obs[3:0], aout_obs[3:0], din_obs, dout_obs}, with bit 0 (dout_obs) nearest TDO, and shifts them out least significant bit first.
- R7: The update-data strobe copies the boundary register to {bif_ctl, ain_ctl, aout_ctl, din_ctl, dout_ctl} only while the boundary register is selected. Otherwise these outputs hold their value.
- R8: tp1_link equals ana_test AND bif_ctl[3], and tp2_link equals ana_test AND bif_ctl[2].
- R9: TDO and tdo_en change only on the falling edge of tck. tdo_en is 1 exactly while shift_ir or shift_dr is asserted.
- R10: A test-logic-reset strobe returns the active instruction to bypass on the next rising edge.
- R11: Shifting the instruction register leaves the active modes unchanged until the update-instruction strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset |
| tlr | input | 1 | Test-logic-reset state strobe |
| capture_ir | input | 1 | Capture-instruction strobe |
| shift_ir | input | 1 | Shift-instruction strobe |
| update_ir | input | 1 | Update-instruction strobe |
| capture_dr | input | 1 | Capture-data strobe |
| shift_dr | input | 1 | Shift-data strobe |
| update_dr | input | 1 | Update-data strobe |
| tdi | input | 1 | Serial test data in |
| bif_obs | input | 4 | Captured value for the bus-interface control field |
| ain_obs | input | 4 | Captured value for the analog input cell |
| aout_obs | input | 4 | Captured value for the analog output cell |
| din_obs | input | 1 | Captured value for the digital input cell |
| dout_obs | input | 1 | Captured value for the digital output cell |
| tdo | output | 1 | Serial test data out, falling-edge registered |
| tdo_en | output | 1 | TDO output enable |
| dig_test | output | 1 | Digital cells drive the pins from their update stage |
| ana_test | output | 1 | Analog cells obey their control words |
| tp1_link | output | 1 | Connect test-port pin 1 to internal bus line 1 |
| tp2_link | output | 1 | Connect test-port pin 2 to internal bus line 2 |
| bif_ctl | output | 4 | Update-stage word for the bus-interface control field |
| ain_ctl | output | 4 | Update-stage word for the analog input cell |
| aout_ctl | output | 4 | Update-stage word for the analog output cell |
| din_ctl | output | 1 | Update-stage bit for the digital input cell |
| dout_ctl | output | 1 | Update-stage bit for the digital output cell |

## Verification
The hardest case to reach from the ports is a data-register update or a test-logic-reset that lands while a particular instruction is active. Reaching it takes a full instruction scan followed by a full data scan, both driven strobe by strobe. The stimulus therefore wraps every step in instruction-scan and data-scan tasks. These are invoked with opcodes drawn at random from the four defined codes and from arbitrary bytes, together with random capture and shift data. Directed runs cover the reset-time bypass path, undefined codes next to the defined ones, and a test-logic-reset issued while external test is active.

// File: rtl/mxbs_pkg.sv
package mxbs_pkg;

  // Decoded instruction flags, registered when the instruction is updated
  typedef struct packed {
    logic drive_dig;  // digital cells take pin values from update stage
    logic ana_ctl;    // analog cells and test-bus links follow control words
    logic use_bsr;    // boundary register is the selected data register
  } ir_mode_t;

  localparam ir_mode_t MODE_BYPASS = '0;

endpackage

// File: rtl/mxbs_ir.sv
module mxbs_ir
  import mxbs_pkg::*;
#(
  parameter int              IR_W       = 8,
  parameter logic [IR_W-1:0] OP_EXTEST  = 8'h00,
  parameter logic [IR_W-1:0] OP_PROBE   = 8'h01,
  parameter logic [IR_W-1:0] OP_SAMPLE  = 8'h02,
  parameter logic [IR_W-1:0] OP_BYPASS  = 8'hFF,
  parameter logic [IR_W-1:0] IR_CAPTURE = 8'h01
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     tlr,
  input  logic     capture,
  input  logic     shift,
  input  logic     update,
  input  logic     tdi,
  output logic     ir_so,
  output ir_mode_t mode_q
);

  logic [IR_W-1:0] sh;

  function automatic ir_mode_t decode(input logic [IR_W-1:0] op);
    ir_mode_t m;
    m = MODE_BYPASS;
    if (op == OP_EXTEST)      m = '{drive_dig: 1'b1, ana_ctl: 1'b1, use_bsr: 1'b1};
    else if (op == OP_PROBE)  m = '{drive_dig: 1'b0, ana_ctl: 1'b1, use_bsr: 1'b1};
    else if (op == OP_SAMPLE) m = '{drive_dig: 1'b0, ana_ctl: 1'b0, use_bsr: 1'b1};
    else if (op == OP_BYPASS) m = MODE_BYPASS;
    return m;
  endfunction

  // Capture / shift stage
  always_ff @(posedge clk) begin
    if (rst)          sh <= IR_CAPTURE;
    else if (capture) sh <= IR_CAPTURE;
    else if (shift)   sh <= {tdi, sh[IR_W-1:1]};
  end

  assign ir_so = sh[0];

  // Active instruction, held as decoded flags
  always_ff @(posedge clk) begin
    if (rst || tlr)  mode_q <= MODE_BYPASS;
    else if (update) mode_q <= decode(sh);
  end

endmodule

// File: rtl/mxbs_chain.sv
module mxbs_chain #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sel,
  input  logic         capture,
  input  logic         shift,
  input  logic         tdi,
  input  logic [W-1:0] cap_val,
  output logic [W-1:0] par
);

  generate
    if (W == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst)                par <= '0;
        else if (sel && capture) par <= cap_val;
        else if (sel && shift)   par <= tdi;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst)                par <= '0;
        else if (sel && capture) par <= cap_val;
        else if (sel && shift)   par <= {tdi, par[W-1:1]};
      end
    end
  endgenerate

endmodule

// File: rtl/mxbs_upd.sv
module mxbs_upd #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= din;
  end

endmodule

// File: rtl/mxbs_tdo.sv
module mxbs_tdo (
  input  logic clk,
  input  logic rst,
  input  logic shift_ir,
  input  logic shift_dr,
  input  logic ir_so,
  input  logic dr_so,
  output logic tdo,
  output logic tdo_en
);

  always_ff @(negedge clk) begin
    if (rst) begin
      tdo    <= 1'b0;
      tdo_en <= 1'b0;
    end else begin
      tdo_en <= shift_ir | shift_dr;
      if (shift_ir)      tdo <= ir_so;
      else if (shift_dr) tdo <= dr_so;
    end
  end

endmodule

// File: rtl/mxbs_ctl.sv
module mxbs_ctl
  import mxbs_pkg::*;
#(
  parameter int              IR_W       = 8,
  parameter logic [IR_W-1:0] OP_EXTEST  = 8'h00,
  parameter logic [IR_W-1:0] OP_PROBE   = 8'h01,
  parameter logic [IR_W-1:0] OP_SAMPLE  = 8'h02,
  parameter logic [IR_W-1:0] OP_BYPASS  = 8'hFF,
  parameter logic [IR_W-1:0] IR_CAPTURE = 8'h01,
  parameter int              CTL_W      = 4,
  parameter int              ACELL_W    = 4
) (
  input  logic               tck,
  input  logic               rst,
  input  logic               tlr,
  input  logic               capture_ir,
  input  logic               shift_ir,
  input  logic               update_ir,
  input  logic               capture_dr,
  input  logic               shift_dr,
  input  logic               update_dr,
  input  logic               tdi,
  input  logic [CTL_W-1:0]   bif_obs,
  input  logic [ACELL_W-1:0] ain_obs,
  input  logic [ACELL_W-1:0] aout_obs,
  input  logic               din_obs,
  input  logic               dout_obs,
  output logic               tdo,
  output logic               tdo_en,
  output logic               dig_test,
  output logic               ana_test,
  output logic               tp1_link,
  output logic               tp2_link,
  output logic [CTL_W-1:0]   bif_ctl,
  output logic [ACELL_W-1:0] ain_ctl,
  output logic [ACELL_W-1:0] aout_ctl,
  output logic               din_ctl,
  output logic               dout_ctl
);

  localparam int BSR_W   = CTL_W + 2 * ACELL_W + 2;
  localparam int AIN_HI  = 2 * ACELL_W + 1;
  localparam int AOUT_HI = ACELL_W + 1;

  ir_mode_t          mode;
  logic              ir_so;
  logic [BSR_W-1:0]  bsr_par;
  logic [BSR_W-1:0]  bsr_upd;
  logic [0:0]        byp_par;
  logic              dr_so;

  mxbs_ir #(
    .IR_W(IR_W), .OP_EXTEST(OP_EXTEST), .OP_PROBE(OP_PROBE),
    .OP_SAMPLE(OP_SAMPLE), .OP_BYPASS(OP_BYPASS), .IR_CAPTURE(IR_CAPTURE)
  ) u_ir (
    .clk(tck), .rst(rst), .tlr(tlr), .capture(capture_ir), .shift(shift_ir),
    .update(update_ir), .tdi(tdi), .ir_so(ir_so), .mode_q(mode)
  );

  // Boundary register: field nearest TDI is the bus-interface control field
  mxbs_chain #(.W(BSR_W)) u_bsr (
    .clk(tck), .rst(rst), .sel(mode.use_bsr), .capture(capture_dr),
    .shift(shift_dr), .tdi(tdi),
    .cap_val({bif_obs, ain_obs, aout_obs, din_obs, dout_obs}),
    .par(bsr_par)
  );

  mxbs_upd #(.W(BSR_W)) u_bsr_upd (
    .clk(tck), .rst(rst), .load(update_dr && mode.use_bsr),
    .din(bsr_par), .q(bsr_upd)
  );

  // One-bit bypass register, captures zero
  mxbs_chain #(.W(1)) u_byp (
    .clk(tck), .rst(rst), .sel(!mode.use_bsr), .capture(capture_dr),
    .shift(shift_dr), .tdi(tdi), .cap_val(1'b0), .par(byp_par)
  );

  assign dr_so = mode.use_bsr ? bsr_par[0] : byp_par[0];

  mxbs_tdo u_tdo (
    .clk(tck), .rst(rst), .shift_ir(shift_ir), .shift_dr(shift_dr),
    .ir_so(ir_so), .dr_so(dr_so), .tdo(tdo), .tdo_en(tdo_en)
  );

  assign dig_test = mode.drive_dig;
  assign ana_test = mode.ana_ctl;
  assign bif_ctl  = bsr_upd[BSR_W-1 -: CTL_W];
  assign ain_ctl  = bsr_upd[AIN_HI -: ACELL_W];
  assign aout_ctl = bsr_upd[AOUT_HI -: ACELL_W];
  assign din_ctl  = bsr_upd[1];
  assign dout_ctl = bsr_upd[0];
  assign tp1_link = mode.ana_ctl & bsr_upd[BSR_W-1];
  assign tp2_link = mode.ana_ctl & bsr_upd[BSR_W-2];

endmodule

// File: rtl/mxbs_chk.sv
module mxbs_chk #(
  parameter int W = 14
) (
  input logic         clk,
  input logic         rst,
  input logic         tlr,
  input logic         shift_ir,
  input logic         shift_dr,
  input logic         update_ir,
  input logic         update_dr,
  input logic         tdo_en,
  input logic         dig_test,
  input logic         ana_test,
  input logic         tp1_link,
  input logic         tp2_link,
  input logic [W-1:0] ctl_all
);

  assert_tlr_bypass_R10: assert property (@(posedge clk) disable iff (rst)
    tlr |=> (!dig_test && !ana_test));

  assert_mode_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (!update_ir && !tlr) |=> ($stable(dig_test) && $stable(ana_test)));

  assert_extest_modes_R3: assert property (@(posedge clk) disable iff (rst)
    dig_test |-> ana_test);

  assert_link_gate_R8: assert property (@(posedge clk) disable iff (rst)
    (tp1_link || tp2_link) |-> ana_test);

  assert_upd_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !update_dr |=> $stable(ctl_all));

  assert_tdo_en_R9: assert property (@(posedge clk) disable iff (rst)
    tdo_en == (shift_ir || shift_dr));

endmodule

bind mxbs_ctl mxbs_chk #(.W(BSR_W)) u_chk (
  .clk(tck), .rst(rst), .tlr(tlr), .shift_ir(shift_ir), .shift_dr(shift_dr),
  .update_ir(update_ir), .update_dr(update_dr), .tdo_en(tdo_en),
  .dig_test(dig_test), .ana_test(ana_test), .tp1_link(tp1_link),
  .tp2_link(tp2_link), .ctl_all(bsr_upd)
);

// File: tb/tb_mxbs_ctl.sv
`timescale 1ns/1ps
module tb_mxbs_ctl;

  localparam logic [6:0] S_IDLE = 7'b0000000;
  localparam logic [6:0] S_TLR  = 7'b1000000;
  localparam logic [6:0] S_CIR  = 7'b0100000;
  localparam logic [6:0] S_SIR  = 7'b0010000;
  localparam logic [6:0] S_UIR  = 7'b0001000;
  localparam logic [6:0] S_CDR  = 7'b0000100;
  localparam logic [6:0] S_SDR  = 7'b0000010;
  localparam logic [6:0] S_UDR  = 7'b0000001;

  logic tck = 1'b0;
  always #10 tck = ~tck;

  logic rst = 1'b1;
  logic tlr = 0, capture_ir = 0, shift_ir = 0, update_ir = 0;
  logic capture_dr = 0, shift_dr = 0, update_dr = 0, tdi = 0;
  logic [3:0] bif_obs = 0, ain_obs = 0, aout_obs = 0;
  logic din_obs = 0, dout_obs = 0;
  logic tdo, tdo_en, dig_test, ana_test, tp1_link, tp2_link;
  logic [3:0] bif_ctl, ain_ctl, aout_ctl;
  logic din_ctl, dout_ctl;

  mxbs_ctl dut (
    .tck(tck), .rst(rst), .tlr(tlr), .capture_ir(capture_ir), .shift_ir(shift_ir),
    .update_ir(update_ir), .capture_dr(capture_dr), .shift_dr(shift_dr),
    .update_dr(update_dr), .tdi(tdi), .bif_obs(bif_obs), .ain_obs(ain_obs),
    .aout_obs(aout_obs), .din_obs(din_obs), .dout_obs(dout_obs), .tdo(tdo),
    .tdo_en(tdo_en), .dig_test(dig_test), .ana_test(ana_test),
    .tp1_link(tp1_link), .tp2_link(tp2_link), .bif_ctl(bif_ctl),
    .ain_ctl(ain_ctl), .aout_ctl(aout_ctl), .din_ctl(din_ctl), .dout_ctl(dout_ctl)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit armed = 1'b0;
  logic prev_tdo = 1'b0;

  // Bench model state
  logic [2:0]  m_mode = 3'b000;   // {dig, ana, bsr}
  logic [13:0] m_upd  = '0;

  task automatic check(input bit ok, input string tag, input logic [15:0] act,
                       input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] mode_of(input logic [7:0] op);
    case (op)
      8'h00:   return 3'b111;
      8'h01:   return 3'b011;
      8'h02:   return 3'b001;
      default: return 3'b000;
    endcase
  endfunction

  task automatic cyc(input logic [6:0] st, input logic d, output logic o_tdo,
                     output logic o_en);
    @(posedge tck); #1;
    if (armed) check(tdo === prev_tdo, "R9 tdo steady after rising edge", tdo, prev_tdo);
    {tlr, capture_ir, shift_ir, update_ir, capture_dr, shift_dr, update_dr} = st;
    tdi = d;
    @(negedge tck); #1;
    o_tdo = tdo;
    o_en = tdo_en;
    prev_tdo = tdo;
    armed = 1'b1;
  endtask

  task automatic check_modes(input string tag);
    check(dig_test === m_mode[2], {tag, " dig_test"}, dig_test, m_mode[2]);
    check(ana_test === m_mode[1], {tag, " ana_test"}, ana_test, m_mode[1]);
  endtask

  task automatic check_outs();
    logic [13:0] ctl;
    ctl = {bif_ctl, ain_ctl, aout_ctl, din_ctl, dout_ctl};
    check(ctl === m_upd, "R7 update-stage outputs", ctl, m_upd);
    check(tp1_link === (m_mode[1] & m_upd[13]), "R8 tp1_link", tp1_link, m_mode[1] & m_upd[13]);
    check(tp2_link === (m_mode[1] & m_upd[12]), "R8 tp2_link", tp2_link, m_mode[1] & m_upd[12]);
  endtask

  task automatic scan_ir(input logic [7:0] op);
    logic t, e;
    logic [7:0] cap;
    cyc(S_CIR, 1'b0, t, e);
    check(e === 1'b0, "R9 tdo_en low in capture", e, 1'b0);
    for (int i = 0; i < 8; i++) begin
      cyc(S_SIR, op[i], t, e);
      cap[i] = t;
      check(e === 1'b1, "R9 tdo_en high in shift-ir", e, 1'b1);
    end
    check_modes("R11 modes held during ir shift");
    cyc(S_UIR, 1'b0, t, e);
    cyc(S_IDLE, 1'b0, t, e);
    check(e === 1'b0, "R9 tdo_en low when idle", e, 1'b0);
    check(cap === 8'h01, "R2 ir capture pattern", cap, 8'h01);
    m_mode = mode_of(op);
    if (op == 8'h00 || op == 8'h01 || op == 8'h02 || op == 8'hFF)
      check_modes("R3 decoded modes");
    else
      check_modes("R4 undefined opcode modes");
  endtask

  task automatic scan_dr(input logic [13:0] v, input string tag);
    logic t, e;
    logic [13:0] outv, expv, cap;
    cap = {bif_obs, ain_obs, aout_obs, din_obs, dout_obs};
    cyc(S_CDR, 1'b0, t, e);
    for (int i = 0; i < 14; i++) begin
      cyc(S_SDR, v[i], t, e);
      outv[i] = t;
      check(e === 1'b1, "R9 tdo_en high in shift-dr", e, 1'b1);
    end
    cyc(S_UDR, 1'b0, t, e);
    cyc(S_IDLE, 1'b0, t, e);
    if (m_mode[0]) begin
      expv = cap;
      m_upd = v;
      check(outv === expv, {tag, " R6 boundary capture out"}, outv, expv);
    end else begin
      expv = {v[12:0], 1'b0};
      check(outv === expv, {tag, " R5 bypass path"}, outv, expv);
    end
    check_outs();
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #(20 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog all requirements actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    logic t, e;
    logic [7:0] op;
    void'($urandom(32'd4242));
    repeat (3) @(posedge tck);
    #1 rst = 1'b0;
    @(negedge tck); #1;
    prev_tdo = tdo;
    armed = 1'b1;
    // R1 reset state
    check(tdo_en === 1'b0, "R1 tdo_en after reset", tdo_en, 1'b0);
    check_modes("R1 reset modes");
    check_outs();
    bif_obs = 4'hA; ain_obs = 4'h3; aout_obs = 4'hC; din_obs = 1; dout_obs = 0;
    scan_dr(14'h2B5D, "R1 bypass after reset");

    // Directed opcodes
    scan_ir(8'h00);
    scan_dr(14'h3FFF, "R3 extest");
    scan_ir(8'h01);
    scan_dr(14'h2001, "R3 probe tp1 only");
    scan_dr(14'h1002, "R3 probe tp2 only");
    scan_ir(8'h02);
    scan_dr(14'h0AAA, "R3 sample");
    scan_ir(8'h55);
    scan_dr(14'h1234, "R4 undefined 55");
    scan_ir(8'h80);
    scan_dr(14'h3333, "R4 undefined 80");
    scan_ir(8'h03);
    scan_dr(14'h0F0F, "R4 undefined 03");
    scan_ir(8'hFF);
    scan_dr(14'h3C3C, "R5 bypass");

    // R10 test-logic-reset while extest is active
    scan_ir(8'h00);
    scan_dr(14'h3001, "R10 preload");
    cyc(S_TLR, 1'b0, t, e);
    cyc(S_IDLE, 1'b0, t, e);
    m_mode = 3'b000;
    check_modes("R10 modes after tlr");
    check_outs();
    scan_dr(14'h15A5, "R10 bypass after tlr");

    // Constrained random
    for (int k = 0; k < 40; k++) begin
      case ($urandom % 5)
        0: op = 8'h00;
        1: op = 8'h01;
        2: op = 8'h02;
        3: op = 8'hFF;
        default: op = 8'($urandom);
      endcase
      bif_obs = 4'($urandom); ain_obs = 4'($urandom); aout_obs = 4'($urandom);
      din_obs = 1'($urandom); dout_obs = 1'($urandom);
      scan_ir(op);
      scan_dr(14'($urandom), "random");
    end

    summary();
    $finish;
  end

endmodule